// File: doc/BRIEF.md
# Gangable Dual-Lane Integer ALU

This block holds two single-cycle integer lanes, each 64 bits wide. In narrow mode each lane takes its own request and the block returns two independent results per cycle. In wide mode the two lanes act as one 128-bit datapath. Lane 0 computes the low half and lane 1 computes the high half. For add, subtract and compare, lane 0's carry-out feeds lane 1's carry-in.

Lane 0 alone also resolves branches. It tests a 4-bit condition code against an incoming NZCV flag vector and produces a taken bit and a target address (base plus offset). Every output is registered and becomes valid exactly one cycle after the request is issued. Scheduling, multi-cycle work and register writeback belong to the surrounding pipeline.

Top module: `dual_lane_alu`

## Requirements
- R1: In narrow mode (`wide_i`=0), an accepted request on a lane sets that lane's bit of `out_valid_o` on the clock edge after issue, for exactly one cycle per request, together with its result and flags. The two lanes are independent.
- R2: Opcodes are ADD=0, SUB=1, AND=2, OR=3, XOR=4, CMP=5 and BRANCH=6. ADD and SUB wrap modulo 2^64. CMP returns the difference a-b as its result.
- R3: AND, OR and XOR return the bitwise result and report C=0 and V=0.
- R4: Flag vectors are ordered {N,Z,C,V} in bits [3:0]. N is the result MSB and Z means the result is zero. C is the carry-out for ADD and "no borrow" (a >= b unsigned) for SUB and CMP. V is signed overflow.
- R5: In wide mode, an accepted lane-0 request runs one 128-bit operation on {lane1_a,lane0_a} and {lane1_b,lane0_b}, with the carry chained across the halves. Both `out_valid_o` bits and `wide_o` are set for one cycle. `lane0_res_o` carries the low half and `lane1_res_o` the high half.
- R6: In wide mode, lane 1's own valid bit and opcode are ignored in that cycle. The wide operation uses lane 0's opcode.
- R7: In wide mode, `lane1_nzcv_o` gives the flags of the full 128-bit result, with Z over all 128 bits. `lane0_nzcv_o` gives the flags of the low half taken alone.
- R8: A BRANCH on lane 0 in narrow mode sets `br_valid_o` one cycle later, leaves `out_valid_o[0]` low, and sets `br_target_o` = lane0_a + lane0_b. `br_taken_o` follows the condition code tested against `br_nzcv_i`: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 and 15 always.
- R9: The block rejects three kinds of request and produces no valid output for them: a BRANCH on lane 1, a BRANCH on lane 0 in wide mode, and opcode 7 on either lane.
- R10: While reset is active, and until the first accepted request after it, `out_valid_o`, `wide_o` and `br_valid_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_i | input | 1 | Gang both lanes into one 128-bit operation |
| in_valid_i | input | 2 | Per-lane request valid |
| lane0_op_i | input | 3 | Lane 0 opcode |
| lane0_a_i | input | 64 | Lane 0 operand A (low half / branch base) |
| lane0_b_i | input | 64 | Lane 0 operand B (low half / branch offset) |
| lane1_op_i | input | 3 | Lane 1 opcode |
| lane1_a_i | input | 64 | Lane 1 operand A (high half in wide mode) |
| lane1_b_i | input | 64 | Lane 1 operand B (high half in wide mode) |
| br_cond_i | input | 4 | Branch condition code |
| br_nzcv_i | input | 4 | Flags the branch condition is tested against |
| out_valid_o | output | 2 | Per-lane result valid |
| lane0_res_o | output | 64 | Lane 0 result (low half in wide mode) |
| lane1_res_o | output | 64 | Lane 1 result (high half in wide mode) |
| lane0_nzcv_o | output | 4 | Lane 0 flags |
| lane1_nzcv_o | output | 4 | Lane 1 flags (128-bit flags in wide mode) |
| wide_o | output | 1 | Result pair is one 128-bit result |
| br_valid_o | output | 1 | Branch resolved |
| br_taken_o | output | 1 | Branch condition held |
| br_target_o | output | 64 | Branch target address |

## Verification
Narrow-mode arithmetic is driven with operands at the unsigned wrap point, the signed overflow point and a small borrow case. These separate a wrong carry or a wrong no-borrow convention from a wrong overflow term. In wide mode, the test operands force a carry or borrow across bit 63. This shows whether the chain links the halves, and whether the high lane wrongly uses its own opcode or carry-in. A 128-bit compare whose halves differ in only one half shows whether Z is taken over the whole result. Branches are driven across several condition codes with the flag vector changing, so a swapped flag bit or an inverted condition becomes visible. Rejected request shapes then confirm that nothing valid comes out.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_CMP = 3'd5,
    OP_BR  = 3'd6,
    OP_BAD = 3'd7
  } alu_op_e;

  // flag vector layout {N,Z,C,V}
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FC = 1;
  localparam int FV = 0;

  function automatic logic op_is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
  endfunction

  function automatic logic op_is_legal(alu_op_e op);
    return (op != OP_BR) && (op != OP_BAD);
  endfunction

endpackage

// File: rtl/alu_lane.sv
module alu_lane
  import alu_pkg::*;
#(
  parameter int W = 64
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           carry_in,
  output logic [W-1:0]   res,
  output logic           carry_out,
  output logic           ovf,
  output logic           zero
);

  logic [W:0]   sum;
  logic [W-1:0] b_eff;
  logic         arith;

  always_comb begin
    arith = op_is_arith(op);
    b_eff = (op == OP_ADD) ? b : ~b;
    sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, carry_in};
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_ADD,
      OP_SUB,
      OP_CMP:  res = sum[W-1:0];
      default: res = '0;
    endcase
    carry_out = arith & sum[W];
    ovf       = arith & (a[W-1] == b_eff[W-1]) & (sum[W-1] != a[W-1]);
    zero      = (res == '0);
  end

endmodule

// File: rtl/br_unit.sv
module br_unit #(
  parameter int W = 64
) (
  input  logic [3:0]   cond,
  input  logic [3:0]   nzcv,
  input  logic [W-1:0] base,
  input  logic [W-1:0] offset,
  output logic         taken,
  output logic [W-1:0] target
);

  logic n, z, c, v;
  logic pass;

  always_comb begin
    {n, z, c, v} = nzcv;
    unique case (cond[3:1])
      3'd0: pass = z;
      3'd1: pass = c;
      3'd2: pass = n;
      3'd3: pass = v;
      3'd4: pass = c & ~z;
      3'd5: pass = (n == v);
      3'd6: pass = ~z & (n == v);
      default: pass = 1'b1;
    endcase
    // odd codes invert, except the always pair
    taken  = (cond[0] && cond[3:1] != 3'd7) ? ~pass : pass;
    target = base + offset;
  end

endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   acc,
  input  logic         wide_acc,
  input  logic         br_acc,
  input  logic [W-1:0] res0,
  input  logic [W-1:0] res1,
  input  logic [3:0]   nzcv0,
  input  logic [3:0]   nzcv1,
  input  logic         br_taken,
  input  logic [W-1:0] br_target,
  output logic [1:0]   valid_q,
  output logic         wide_q,
  output logic         br_valid_q,
  output logic [W-1:0] res0_q,
  output logic [W-1:0] res1_q,
  output logic [3:0]   nzcv0_q,
  output logic [3:0]   nzcv1_q,
  output logic         br_taken_q,
  output logic [W-1:0] br_target_q
);

  logic [1:0] valid_d;
  logic       wide_d;
  logic       br_valid_d;
  logic       en0, en1, en_br;

  always_comb begin
    valid_d    = acc;
    wide_d     = wide_acc;
    br_valid_d = br_acc;
    en0        = acc[0];
    en1        = acc[1];
    en_br      = br_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= '0;
      wide_q     <= 1'b0;
      br_valid_q <= 1'b0;
    end else begin
      valid_q    <= valid_d;
      wide_q     <= wide_d;
      br_valid_q <= br_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res0_q  <= '0;
      nzcv0_q <= '0;
    end else if (en0) begin
      res0_q  <= res0;
      nzcv0_q <= nzcv0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res1_q  <= '0;
      nzcv1_q <= '0;
    end else if (en1) begin
      res1_q  <= res1;
      nzcv1_q <= nzcv1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_taken_q  <= 1'b0;
      br_target_q <= '0;
    end else if (en_br) begin
      br_taken_q  <= br_taken;
      br_target_q <= br_target;
    end
  end

  // R5
  wide_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wide_q |-> (valid_q == 2'b11));

  // R8
  br_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid_q |-> !valid_q[0]);

  // R7
  wide_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_q && nzcv1_q[2]) |-> (res0_q == '0 && res1_q == '0));

endmodule

// File: rtl/dual_lane_alu.sv
module dual_lane_alu
  import alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wide_i,
  input  logic [1:0]      in_valid_i,
  input  logic [2:0]      lane0_op_i,
  input  logic [XLEN-1:0] lane0_a_i,
  input  logic [XLEN-1:0] lane0_b_i,
  input  logic [2:0]      lane1_op_i,
  input  logic [XLEN-1:0] lane1_a_i,
  input  logic [XLEN-1:0] lane1_b_i,
  input  logic [3:0]      br_cond_i,
  input  logic [3:0]      br_nzcv_i,
  output logic [1:0]      out_valid_o,
  output logic [XLEN-1:0] lane0_res_o,
  output logic [XLEN-1:0] lane1_res_o,
  output logic [3:0]      lane0_nzcv_o,
  output logic [3:0]      lane1_nzcv_o,
  output logic            wide_o,
  output logic            br_valid_o,
  output logic            br_taken_o,
  output logic [XLEN-1:0] br_target_o
);

  localparam int NLANE = 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  alu_op_e         op0, op1, lane_op [NLANE];
  logic [XLEN-1:0] lane_a   [NLANE];
  logic [XLEN-1:0] lane_b   [NLANE];
  logic [XLEN-1:0] lane_res [NLANE];
  logic            lane_cin [NLANE];
  logic            lane_cout[NLANE];
  logic            lane_ovf [NLANE];
  logic            lane_zero[NLANE];
  logic [1:0]      acc;
  logic            wide_acc, br_acc;
  logic [3:0]      nzcv0, nzcv1;
  logic            br_taken;
  logic [XLEN-1:0] br_target;

  always_comb begin
    op0 = alu_op_e'(lane0_op_i);
    op1 = alu_op_e'(lane1_op_i);

    wide_acc = wide_i & in_valid_i[0] & op_is_legal(op0);
    br_acc   = ~wide_i & in_valid_i[0] & (op0 == OP_BR);
    acc[0]   = in_valid_i[0] & op_is_legal(op0);
    acc[1]   = wide_i ? wide_acc : (in_valid_i[1] & op_is_legal(op1));

    lane_op[0] = op0;
    lane_op[1] = wide_i ? op0 : op1;
    lane_a[0]  = lane0_a_i;
    lane_b[0]  = lane0_b_i;
    lane_a[1]  = lane1_a_i;
    lane_b[1]  = lane1_b_i;

    lane_cin[0] = (op0 == OP_SUB) || (op0 == OP_CMP);
    lane_cin[1] = wide_i ? lane_cout[0]
                         : ((op1 == OP_SUB) || (op1 == OP_CMP));
  end

  for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
    alu_lane #(.W(XLEN)) u_lane (
      .op        (lane_op[gi]),
      .a         (lane_a[gi]),
      .b         (lane_b[gi]),
      .carry_in  (lane_cin[gi]),
      .res       (lane_res[gi]),
      .carry_out (lane_cout[gi]),
      .ovf       (lane_ovf[gi]),
      .zero      (lane_zero[gi])
    );
  end

  always_comb begin
    nzcv0 = {lane_res[0][XLEN-1], lane_zero[0], lane_cout[0], lane_ovf[0]};
    nzcv1 = {lane_res[1][XLEN-1],
             wide_i ? (lane_zero[0] & lane_zero[1]) : lane_zero[1],
             lane_cout[1], lane_ovf[1]};
  end

  br_unit #(.W(XLEN)) u_br (
    .cond   (br_cond_i),
    .nzcv   (br_nzcv_i),
    .base   (lane0_a_i),
    .offset (lane0_b_i),
    .taken  (br_taken),
    .target (br_target)
  );

  alu_out_stage #(.W(XLEN)) u_out (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .acc         (acc),
    .wide_acc    (wide_acc),
    .br_acc      (br_acc),
    .res0        (lane_res[0]),
    .res1        (lane_res[1]),
    .nzcv0       (nzcv0),
    .nzcv1       (nzcv1),
    .br_taken    (br_taken),
    .br_target   (br_target),
    .valid_q     (out_valid_o),
    .wide_q      (wide_o),
    .br_valid_q  (br_valid_o),
    .res0_q      (lane0_res_o),
    .res1_q      (lane1_res_o),
    .nzcv0_q     (lane0_nzcv_o),
    .nzcv1_q     (lane1_nzcv_o),
    .br_taken_q  (br_taken_o),
    .br_target_q (br_target_o)
  );

  // R1
  lane0_latency_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid_i[0] && lane0_op_i <= 3'd5) |=> out_valid_o[0]);

  // R9
  lane1_br_reject_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wide_i && in_valid_i[1] && lane1_op_i == 3'd6) |=> !out_valid_o[1]);

  // R9
  wide_br_reject_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wide_i && lane0_op_i == 3'd6) |=> (!br_valid_o && out_valid_o == 2'b00));

  // R3
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wide_i && in_valid_i[1] && lane1_op_i inside {3'd2, 3'd3, 3'd4})
      |=> (lane1_nzcv_o[1:0] == 2'b00));

endmodule

// File: tb/tb_dual_lane_alu.sv
`timescale 1ns/1ps
module tb_dual_lane_alu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wide_i;
  logic [1:0]  in_valid_i;
  logic [2:0]  lane0_op_i, lane1_op_i;
  logic [63:0] lane0_a_i, lane0_b_i, lane1_a_i, lane1_b_i;
  logic [3:0]  br_cond_i, br_nzcv_i;
  logic [1:0]  out_valid_o;
  logic [63:0] lane0_res_o, lane1_res_o, br_target_o;
  logic [3:0]  lane0_nzcv_o, lane1_nzcv_o;
  logic        wide_o, br_valid_o, br_taken_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_lane_alu dut (
    .clk(clk), .rst_n(rst_n), .wide_i(wide_i), .in_valid_i(in_valid_i),
    .lane0_op_i(lane0_op_i), .lane0_a_i(lane0_a_i), .lane0_b_i(lane0_b_i),
    .lane1_op_i(lane1_op_i), .lane1_a_i(lane1_a_i), .lane1_b_i(lane1_b_i),
    .br_cond_i(br_cond_i), .br_nzcv_i(br_nzcv_i),
    .out_valid_o(out_valid_o), .lane0_res_o(lane0_res_o), .lane1_res_o(lane1_res_o),
    .lane0_nzcv_o(lane0_nzcv_o), .lane1_nzcv_o(lane1_nzcv_o), .wide_o(wide_o),
    .br_valid_o(br_valid_o), .br_taken_o(br_taken_o), .br_target_o(br_target_o)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: {nzcv, result} for a 64-bit op
  function automatic logic [67:0] ref64(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [64:0] s;
    logic [63:0] r;
    logic c, v;
    c = 0; v = 0; r = '0;
    case (op)
      3'd0: begin s = {1'b0, a} + {1'b0, b}; r = s[63:0]; c = s[64];
                  v = (a[63] == b[63]) && (r[63] != a[63]); end
      3'd1, 3'd5: begin r = a - b; c = (a >= b);
                  v = (a[63] != b[63]) && (r[63] != a[63]); end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      default: r = '0;
    endcase
    return {r[63], r == 64'd0, c, v, r};
  endfunction

  function automatic logic [131:0] ref128(input logic [2:0] op, input logic [127:0] a, input logic [127:0] b);
    logic [128:0] s;
    logic [127:0] r;
    logic c, v;
    c = 0; v = 0; r = '0;
    case (op)
      3'd0: begin s = {1'b0, a} + {1'b0, b}; r = s[127:0]; c = s[128];
                  v = (a[127] == b[127]) && (r[127] != a[127]); end
      3'd1, 3'd5: begin r = a - b; c = (a >= b);
                  v = (a[127] != b[127]) && (r[127] != a[127]); end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      default: r = '0;
    endcase
    return {r[127], r == 128'd0, c, v, r};
  endfunction

  function automatic logic cond_ref(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0: return z;          4'd1: return !z;
      4'd2: return c;          4'd3: return !c;
      4'd4: return n;          4'd5: return !n;
      4'd6: return v;          4'd7: return !v;
      4'd8: return c && !z;    4'd9: return !c || z;
      4'd10: return n == v;    4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic idle();
    wide_i = 0; in_valid_i = 0; lane0_op_i = 0; lane1_op_i = 0;
    lane0_a_i = 0; lane0_b_i = 0; lane1_a_i = 0; lane1_b_i = 0;
    br_cond_i = 0; br_nzcv_i = 0;
  endtask

  // drive one request at a falling edge, return at the next falling edge
  task automatic issue(input logic w, input logic [1:0] v,
                       input logic [2:0] o0, input logic [63:0] a0, input logic [63:0] b0,
                       input logic [2:0] o1, input logic [63:0] a1, input logic [63:0] b1,
                       input logic [3:0] cc, input logic [3:0] f);
    @(negedge clk);
    wide_i = w; in_valid_i = v;
    lane0_op_i = o0; lane0_a_i = a0; lane0_b_i = b0;
    lane1_op_i = o1; lane1_a_i = a1; lane1_b_i = b1;
    br_cond_i = cc; br_nzcv_i = f;
    @(negedge clk);
    idle();
  endtask

  task automatic narrow_pair(input string req, input logic [2:0] o0, input logic [63:0] a0, input logic [63:0] b0,
                             input logic [2:0] o1, input logic [63:0] a1, input logic [63:0] b1);
    logic [67:0] e0, e1;
    e0 = ref64(o0, a0, b0);
    e1 = ref64(o1, a1, b1);
    issue(0, 2'b11, o0, a0, b0, o1, a1, b1, 0, 0);
    chk({req, " valid"}, out_valid_o, 2'b11);
    chk({req, " lane0 res"}, lane0_res_o, e0[63:0]);
    chk({req, " lane0 nzcv"}, lane0_nzcv_o, e0[67:64]);
    chk({req, " lane1 res"}, lane1_res_o, e1[63:0]);
    chk({req, " lane1 nzcv"}, lane1_nzcv_o, e1[67:64]);
    chk({req, " wide flag"}, wide_o, 0);
  endtask

  task automatic t_reset();
    chk("R10 reset valid", {out_valid_o, wide_o, br_valid_o}, 0);
  endtask

  task automatic t_arith();
    narrow_pair("R1 R2 R4 add wrap / sub borrow", 3'd0, '1, 64'd1, 3'd1, 64'd5, 64'd7);
    narrow_pair("R4 signed overflow add / sub", 3'd0, 64'h7fff_ffff_ffff_ffff, 64'd1,
                3'd1, 64'h8000_0000_0000_0000, 64'd1);
    narrow_pair("R2 R4 cmp equal / cmp less", 3'd5, 64'h1234, 64'h1234, 3'd5, 64'd3, 64'd9);
  endtask

  task automatic t_logic();
    narrow_pair("R3 and / or", 3'd2, 64'hf0f0_aaaa_0000_ffff, 64'hff00_5555_ffff_0f0f,
                3'd3, 64'h8000_0000_0000_0000, 64'h1);
    narrow_pair("R3 xor / and zero", 3'd4, 64'hdead_beef_0123_4567, 64'hffff_0000_ffff_0000,
                3'd2, 64'hff00, 64'h00ff);
  endtask

  task automatic t_single_pulse();
    logic [67:0] e0;
    e0 = ref64(3'd0, 64'd40, 64'd2);
    issue(0, 2'b01, 3'd0, 64'd40, 64'd2, 3'd0, 0, 0, 0, 0);
    chk("R1 only lane0 valid", out_valid_o, 2'b01);
    chk("R1 lane0 res", lane0_res_o, e0[63:0]);
    @(negedge clk);
    chk("R1 valid lasts one cycle", out_valid_o, 2'b00);
  endtask

  task automatic wide_case(input string req, input logic [2:0] op, input logic [127:0] a, input logic [127:0] b,
                           input logic [2:0] junk_op);
    logic [131:0] e;
    logic [67:0]  lo;
    e  = ref128(op, a, b);
    lo = ref64(op, a[63:0], b[63:0]);
    issue(1, 2'b11, op, a[63:0], b[63:0], junk_op, a[127:64], b[127:64], 0, 0);
    chk({req, " R5 valid pair"}, {out_valid_o, wide_o}, 3'b111);
    chk({req, " R5 128-bit result"}, {lane1_res_o, lane0_res_o}, e[127:0]);
    chk({req, " R7 full flags"}, lane1_nzcv_o, e[131:128]);
    chk({req, " R7 low flags"}, lane0_nzcv_o, lo[67:64]);
  endtask

  task automatic t_wide();
    wide_case("wide add carry across, R6 lane1 xor ignored", 3'd0,
              {64'd0, 64'hffff_ffff_ffff_ffff}, {64'd0, 64'd1}, 3'd4);
    wide_case("wide sub borrow across", 3'd1,
              {64'd1, 64'd0}, {64'd0, 64'd1}, 3'd2);
    wide_case("wide cmp high differs only", 3'd5,
              {64'd7, 64'h55}, {64'd6, 64'h55}, 3'd0);
    wide_case("wide cmp equal", 3'd5,
              {64'h9, 64'h3}, {64'h9, 64'h3}, 3'd1);
    wide_case("wide signed overflow", 3'd0,
              {64'h7fff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff}, {64'd0, 64'd1}, 3'd1);
    wide_case("wide or", 3'd3,
              {64'hf000, 64'h000f}, {64'h0f00, 64'h00f0}, 3'd0);
    // R6: lane1 issuing a branch in wide mode is also ignored
    wide_case("wide add, R6 lane1 branch ignored", 3'd0,
              {64'd2, 64'd3}, {64'd4, 64'd5}, 3'd6);
  endtask

  task automatic t_branch();
    logic [3:0] flags [4];
    flags[0] = 4'b0100; flags[1] = 4'b1001; flags[2] = 4'b0010; flags[3] = 4'b1000;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] f;
      f = flags[i % 4];
      issue(0, 2'b01, 3'd6, 64'h1000 + i, 64'h40, 3'd0, 0, 0, i[3:0], f);
      chk("R8 branch valid", {br_valid_o, out_valid_o[0]}, 2'b10);
      chk("R8 branch taken", br_taken_o, cond_ref(i[3:0], f));
      chk("R8 branch target", br_target_o, 64'h1040 + i);
    end
    issue(0, 2'b01, 3'd6, 64'hffff_ffff_ffff_fff0, 64'h20, 3'd0, 0, 0, 4'd11, 4'b0001);
    chk("R8 target wraps", br_target_o, 64'h10);
    chk("R8 lt taken when N!=V", br_taken_o, 1'b1);
  endtask

  task automatic t_reject();
    issue(0, 2'b10, 3'd0, 0, 0, 3'd6, 64'd1, 64'd2, 4'd14, 0);
    chk("R9 lane1 branch rejected", {out_valid_o, br_valid_o}, 3'b000);
    issue(1, 2'b11, 3'd6, 64'd1, 64'd2, 3'd0, 0, 0, 4'd14, 0);
    chk("R9 wide branch rejected", {out_valid_o, wide_o, br_valid_o}, 4'b0000);
    issue(0, 2'b11, 3'd7, 64'd1, 64'd2, 3'd7, 64'd3, 64'd4, 0, 0);
    chk("R9 opcode 7 rejected", {out_valid_o, br_valid_o}, 3'b000);
    issue(1, 2'b11, 3'd7, 64'd1, 64'd2, 3'd0, 64'd3, 64'd4, 0, 0);
    chk("R9 wide opcode 7 rejected", {out_valid_o, wide_o}, 3'b000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_arith();
    t_logic();
    t_single_pulse();
    t_wide();
    t_branch();
    t_reject();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule